// File: doc/BRIEF.md
# PLL Bring-Up Sequencer

This block walks a PLL from whatever state it is in to a configured, locked and enabled state. A request carrying the wanted multiplier M, pre-divider D and output divider OD is offered on a valid/ready pair, together with a flag saying whether the PLL is currently bypassed. The sequencer then waits for the supply to settle and drops the PLL into bypass. If the PLL was already bypassed, it power-cycles it. It then loads the encoded divider and bandwidth fields, pulses reset, waits for lock, leaves bypass and finally enables the output, flagging completion with a one-cycle pulse.

Every wait is counted in reference-clock cycles. Times given in nanoseconds are converted to cycle counts from a reference-frequency parameter, rounding up. The lock wait either uses a fixed time or is derived from the requested pre-divider. The analog PLL is not modelled. Its control inputs appear as registered outputs of this block.

Back-pressure: `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a sequence, including its trailing guard delay, is in progress, `req_ready` stays low and `req_valid` has no effect. A source that keeps `req_valid` high is served once the block is idle again.

Top module: `pll_bringup_seq`

## Requirements
- R1: `req_ready` is high only when idle. A request is accepted on an edge with `req_valid` and `req_ready` high, and `req_ready` falls after that edge. A `req_valid` pulse while `req_ready` is low neither starts a sequence nor alters any output.
- R2: The loaded fields are `pll_mult` = M−1, `pll_prediv` = D−1 and `pll_postdiv` = OD−1, at the widths of the request inputs. They are loaded once per sequence, before reset rises, and they hold until the next sequence loads.
- R3: The bandwidth value is (M−1) >> 1. Its lowest BWL_W bits appear on `pll_bw_lo` and its remaining upper bits on `pll_bw_hi`.
- R4: After acceptance, `pll_en` and `pll_bypass` are unchanged for the settle count. On the edge where that count ends, `pll_en` clears and `pll_bypass` sets.
- R5: After bypass is entered, nothing else changes for exactly QUIESCE_CYC (default 4) cycles: no power-down, no field load and no reset.
- R6: If `in_bypass` was high at acceptance, `pll_sat_en` sets (it is sticky) and `pll_pwrdn` is high for the power-down count right after the quiet wait. Otherwise `pll_pwrdn` never rises.
- R7: `pll_rst` rises one cycle after the field load and stays high for the reset count, while the PLL is bypassed and not powered down.
- R8: Lock wait is measured from the fall of `pll_rst` to the fall of `pll_bypass`. With LOCK_BY_DIV=0 it is the lock count. With LOCK_BY_DIV=1 it is LOCK_PER_DIV × D cycles, where D is the requested pre-divider (encoded field + 1).
- R9: `pll_bypass` clears one cycle before `pll_en` sets. `done` is high for exactly the one cycle in which `pll_en` first reads high.
- R10: `req_ready` returns the guard count plus one cycle after the `done` cycle.
- R11: Each nanosecond-specified wait lasts ceil(ns × REF_KHZ / 1,000,000) cycles. For example, at 9,990 kHz: settle 100,000 ns gives 999 cycles, power-down 5,000 ns gives 50, reset 7,000 ns gives 70, lock 50,000 ns gives 500, and guard 100,000 ns gives 999.
- R12: After reset: `req_ready`=1, `pll_bypass`=1, and `pll_en`, `pll_pwrdn`, `pll_rst`, `pll_sat_en` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_m | input | M_W | Requested multiplier M |
| req_d | input | D_W | Requested pre-divider D |
| req_od | input | OD_W | Requested output divider OD |
| in_bypass | input | 1 | PLL currently bypassed, sampled at acceptance |
| pll_mult | output | M_W | Multiplier field, M−1 |
| pll_prediv | output | D_W | Pre-divider field, D−1 |
| pll_postdiv | output | OD_W | Output divider field, OD−1 |
| pll_bw_lo | output | BWL_W | Low bits of bandwidth value |
| pll_bw_hi | output | M_W−1−BWL_W | Upper bits of bandwidth value |
| pll_sat_en | output | 1 | Saturation enable |
| pll_bypass | output | 1 | Bypass select |
| pll_pwrdn | output | 1 | Power-down |
| pll_rst | output | 1 | PLL reset |
| pll_en | output | 1 | PLL output enable |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a request arriving in the middle of a running sequence, with a field value that differs from the one being applied. Its effect, or lack of one, only shows after reset and lock have finished. The bench pulses `req_valid` with a different multiplier halfway through the lock wait. It then checks that exactly one `done` appears, that the loaded fields still match the first request, and that the block stays idle and enabled afterwards. The power-cycle branch depends on the PLL having been reported as bypassed, so the first sequence after reset is issued with `in_bypass` high, and the next with it low. This exposes the settle edge on `pll_en`.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_QUIESCE,
    ST_PWRDN,
    ST_LOAD,
    ST_RESET,
    ST_LOCK,
    ST_UNBYP,
    ST_ENABLE,
    ST_GUARD
  } seq_state_t;

  // cycles = ceil(ns * khz / 1e6), never below one
  function automatic int ns_to_cyc(input longint ns, input longint khz);
    longint c;
    c = (ns * khz + 64'd999999) / 64'd1000000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pbs_encode.sv
module pbs_encode #(
  parameter int M_W   = 12,
  parameter int D_W   = 6,
  parameter int OD_W  = 4,
  parameter int BWL_W = 8,
  parameter int BWH_W = 3
) (
  input  logic [M_W-1:0]   m,
  input  logic [D_W-1:0]   d,
  input  logic [OD_W-1:0]  od,
  output logic [M_W-1:0]   mult_f,
  output logic [D_W-1:0]   prediv_f,
  output logic [OD_W-1:0]  postdiv_f,
  output logic [BWL_W-1:0] bw_lo_f,
  output logic [BWH_W-1:0] bw_hi_f
);

  logic [M_W-2:0] bw_full;

  assign mult_f    = m - M_W'(1);
  assign prediv_f  = d - D_W'(1);
  assign postdiv_f = od - OD_W'(1);
  assign bw_full   = mult_f[M_W-1:1];
  assign bw_lo_f   = bw_full[BWL_W-1:0];
  assign bw_hi_f   = bw_full[M_W-2:BWL_W];

endmodule

// File: rtl/pbs_timer.sv
module pbs_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pbs_fsm.sv
module pbs_fsm
  import pbs_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SET_C       = 10,
  parameter int QUIESCE_CYC = 4,
  parameter int PWR_C       = 5,
  parameter int RST_C       = 7,
  parameter int GRD_C       = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          was_byp,
  input  logic [CW-1:0] lock_cyc,
  output seq_state_t    state_q,
  output seq_state_t    state_d,
  output logic          req_ready
);

  logic          expired;
  logic          load;
  logic [CW-1:0] dur;
  logic [CW-1:0] dur_m1;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_valid) state_d = ST_SETTLE;
      ST_SETTLE:  if (expired) state_d = ST_QUIESCE;
      ST_QUIESCE: if (expired) state_d = was_byp ? ST_PWRDN : ST_LOAD;
      ST_PWRDN:   if (expired) state_d = ST_LOAD;
      ST_LOAD:    state_d = ST_RESET;
      ST_RESET:   if (expired) state_d = ST_LOCK;
      ST_LOCK:    if (expired) state_d = ST_UNBYP;
      ST_UNBYP:   state_d = ST_ENABLE;
      ST_ENABLE:  state_d = ST_GUARD;
      ST_GUARD:   if (expired) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_SETTLE:  dur = CW'(SET_C);
      ST_QUIESCE: dur = CW'(QUIESCE_CYC);
      ST_PWRDN:   dur = CW'(PWR_C);
      ST_RESET:   dur = CW'(RST_C);
      ST_LOCK:    dur = lock_cyc;
      ST_GUARD:   dur = CW'(GRD_C);
      default:    dur = CW'(1);
    endcase
    dur_m1 = (dur == '0) ? '0 : dur - CW'(1);
  end

  assign load = (state_d != state_q);

  pbs_timer #(.CW(CW)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (dur_m1),
    .expired  (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign req_ready = (state_q == ST_IDLE);

endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
  import pbs_pkg::*;
#(
  parameter int M_W          = 12,
  parameter int D_W          = 6,
  parameter int OD_W         = 4,
  parameter int BWL_W        = 8,
  parameter int REF_KHZ      = 100000,
  parameter int SETTLE_NS    = 100000,
  parameter int PWRDN_NS     = 5000,
  parameter int RST_NS       = 7000,
  parameter int LOCK_NS      = 50000,
  parameter int GUARD_NS     = 100000,
  parameter int QUIESCE_CYC  = 4,
  parameter bit LOCK_BY_DIV  = 1'b0,
  parameter int LOCK_PER_DIV = 500
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [M_W-1:0]           req_m,
  input  logic [D_W-1:0]           req_d,
  input  logic [OD_W-1:0]          req_od,
  input  logic                     in_bypass,
  output logic [M_W-1:0]           pll_mult,
  output logic [D_W-1:0]           pll_prediv,
  output logic [OD_W-1:0]          pll_postdiv,
  output logic [BWL_W-1:0]         pll_bw_lo,
  output logic [M_W-2-BWL_W:0]     pll_bw_hi,
  output logic                     pll_sat_en,
  output logic                     pll_bypass,
  output logic                     pll_pwrdn,
  output logic                     pll_rst,
  output logic                     pll_en,
  output logic                     done
);

  localparam int BWH_W    = M_W - 1 - BWL_W;
  localparam int SET_C    = ns_to_cyc(SETTLE_NS, REF_KHZ);
  localparam int PWR_C    = ns_to_cyc(PWRDN_NS, REF_KHZ);
  localparam int RST_C    = ns_to_cyc(RST_NS, REF_KHZ);
  localparam int LOCK_C   = ns_to_cyc(LOCK_NS, REF_KHZ);
  localparam int GRD_C    = ns_to_cyc(GUARD_NS, REF_KHZ);
  localparam int LOCK_MAX = LOCK_BY_DIV ? LOCK_PER_DIV * ((1 << D_W) - 1) : LOCK_C;
  localparam int MAX_C    = max2(max2(max2(SET_C, GRD_C), max2(PWR_C, RST_C)),
                                 max2(LOCK_MAX, QUIESCE_CYC));
  localparam int CW       = $clog2(MAX_C + 1);

  seq_state_t      state_q;
  seq_state_t      state_d;
  logic            accept;
  logic            byp_q;
  logic [M_W-1:0]  m_q;
  logic [D_W-1:0]  d_q;
  logic [OD_W-1:0] od_q;
  logic [CW-1:0]   lock_cyc;

  logic [M_W-1:0]   mult_f;
  logic [D_W-1:0]   prediv_f;
  logic [OD_W-1:0]  postdiv_f;
  logic [BWL_W-1:0] bw_lo_f;
  logic [BWH_W-1:0] bw_hi_f;

  assign accept = req_valid && req_ready;

  // request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
      m_q   <= '0;
      d_q   <= '0;
      od_q  <= '0;
    end else if (accept) begin
      byp_q <= in_bypass;
      m_q   <= req_m;
      d_q   <= req_d;
      od_q  <= req_od;
    end
  end

  generate
    if (LOCK_BY_DIV) begin : g_lock_div
      assign lock_cyc = CW'(LOCK_PER_DIV * int'({1'b0, d_q}));
    end else begin : g_lock_fix
      assign lock_cyc = CW'(LOCK_C);
    end
  endgenerate

  pbs_encode #(
    .M_W(M_W), .D_W(D_W), .OD_W(OD_W), .BWL_W(BWL_W), .BWH_W(BWH_W)
  ) enc_i (
    .m         (m_q),
    .d         (d_q),
    .od        (od_q),
    .mult_f    (mult_f),
    .prediv_f  (prediv_f),
    .postdiv_f (postdiv_f),
    .bw_lo_f   (bw_lo_f),
    .bw_hi_f   (bw_hi_f)
  );

  pbs_fsm #(
    .CW(CW), .SET_C(SET_C), .QUIESCE_CYC(QUIESCE_CYC),
    .PWR_C(PWR_C), .RST_C(RST_C), .GRD_C(GRD_C)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .was_byp   (byp_q),
    .lock_cyc  (lock_cyc),
    .state_q   (state_q),
    .state_d   (state_d),
    .req_ready (req_ready)
  );

  // PLL control outputs, updated on the edge that enters each step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_mult    <= '0;
      pll_prediv  <= '0;
      pll_postdiv <= '0;
      pll_bw_lo   <= '0;
      pll_bw_hi   <= '0;
      pll_sat_en  <= 1'b0;
      pll_bypass  <= 1'b1;
      pll_pwrdn   <= 1'b0;
      pll_rst     <= 1'b0;
      pll_en      <= 1'b0;
      done        <= 1'b0;
    end else begin
      if (state_d == ST_QUIESCE && state_q != ST_QUIESCE) begin
        pll_en     <= 1'b0;
        pll_bypass <= 1'b1;
        if (byp_q) pll_sat_en <= 1'b1;
      end
      if (state_d == ST_LOAD) begin
        pll_mult    <= mult_f;
        pll_prediv  <= prediv_f;
        pll_postdiv <= postdiv_f;
        pll_bw_lo   <= bw_lo_f;
        pll_bw_hi   <= bw_hi_f;
      end
      if (state_d == ST_UNBYP)  pll_bypass <= 1'b0;
      if (state_d == ST_ENABLE) pll_en     <= 1'b1;
      pll_pwrdn <= (state_d == ST_PWRDN);
      pll_rst   <= (state_d == ST_RESET);
      done      <= (state_d == ST_ENABLE);
    end
  end

endmodule

// File: rtl/pbs_chk.sv
module pbs_chk #(
  parameter int M_W   = 12,
  parameter int BWL_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [M_W-1:0]       pll_mult,
  input logic [BWL_W-1:0]     pll_bw_lo,
  input logic [M_W-2-BWL_W:0] pll_bw_hi,
  input logic                 pll_bypass,
  input logic                 pll_pwrdn,
  input logic                 pll_rst,
  input logic                 pll_en,
  input logic                 done
);

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R1

  AST_BW_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    {pll_bw_hi, pll_bw_lo} == pll_mult[M_W-1:1]); // R3

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst |-> $stable(pll_mult)); // R2

  AST_PWRDN_CTX: assert property (@(posedge clk) disable iff (!rst_n)
    pll_pwrdn |-> (pll_bypass && !pll_en && !req_ready)); // R6

  AST_RST_CTX: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst |-> (pll_bypass && !pll_pwrdn && !pll_en)); // R7

  AST_BYP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> $past(!pll_bypass)); // R9

  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_EN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(pll_en)); // R9

endmodule

bind pll_bringup_seq pbs_chk #(.M_W(M_W), .BWL_W(BWL_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .pll_mult   (pll_mult),
  .pll_bw_lo  (pll_bw_lo),
  .pll_bw_hi  (pll_bw_hi),
  .pll_bypass (pll_bypass),
  .pll_pwrdn  (pll_pwrdn),
  .pll_rst    (pll_rst),
  .pll_en     (pll_en),
  .done       (done)
);

// File: tb/pll_bringup_seq_tb_top.sv
`timescale 1ns/1ps
module pll_bringup_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_valid2 = 1'b0;
  logic [11:0] req_m = 12'd1;
  logic [5:0]  req_d = 6'd1;
  logic [3:0]  req_od = 4'd1;
  logic        in_bypass = 1'b0;

  logic        ready, sat, byp, pwr, rst, en, done;
  logic [11:0] mult;
  logic [5:0]  prediv;
  logic [3:0]  postdiv;
  logic [7:0]  bw_lo;
  logic [2:0]  bw_hi;

  logic        ready2, sat2, byp2, pwr2, rst2, en2, done2;
  logic [11:0] mult2;
  logic [5:0]  prediv2;
  logic [3:0]  postdiv2;
  logic [7:0]  bw_lo2;
  logic [2:0]  bw_hi2;

  pll_bringup_seq #(.REF_KHZ(9990), .LOCK_BY_DIV(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(ready),
    .req_m(req_m), .req_d(req_d), .req_od(req_od), .in_bypass(in_bypass),
    .pll_mult(mult), .pll_prediv(prediv), .pll_postdiv(postdiv),
    .pll_bw_lo(bw_lo), .pll_bw_hi(bw_hi), .pll_sat_en(sat),
    .pll_bypass(byp), .pll_pwrdn(pwr), .pll_rst(rst), .pll_en(en), .done(done));

  pll_bringup_seq #(.REF_KHZ(9990), .LOCK_BY_DIV(1'b1)) dut2_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid2), .req_ready(ready2),
    .req_m(req_m), .req_d(req_d), .req_od(req_od), .in_bypass(in_bypass),
    .pll_mult(mult2), .pll_prediv(prediv2), .pll_postdiv(postdiv2),
    .pll_bw_lo(bw_lo2), .pll_bw_hi(bw_hi2), .pll_sat_en(sat2),
    .pll_bypass(byp2), .pll_pwrdn(pwr2), .pll_rst(rst2), .pll_en(en2), .done(done2));

  int checks = 0, errors = 0;
  int t_byp_rise, t_en_fall, t_pwr_rise, t_pwr_fall, t_rst_rise, t_rst_fall;
  int t_unbyp, t_en_rise, t_done, t_ready, done_cnt, ready_at_inj;
  int f_mult, f_prediv, f_postdiv, f_lo, f_hi;

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic run_seq(input int m, input int d, input int od, input int bp, input int inj_t);
    int t;
    logic p_byp, p_en, p_pwr, p_rst, p_rdy;
    t_byp_rise = -1; t_en_fall = -1; t_pwr_rise = -1; t_pwr_fall = -1;
    t_rst_rise = -1; t_rst_fall = -1; t_unbyp = -1; t_en_rise = -1;
    t_done = -1; t_ready = -1; done_cnt = 0; ready_at_inj = -1;
    @(negedge clk);
    req_m = 12'(m); req_d = 6'(d); req_od = 4'(od); in_bypass = bp[0];
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    p_byp = byp; p_en = en; p_pwr = pwr; p_rst = rst; p_rdy = ready;
    while (t < 4000 && t_ready < 0) begin
      @(negedge clk);
      t++;
      if (t == inj_t) begin
        ready_at_inj = int'(ready);
        req_m = 12'd7; req_valid = 1'b1;
      end else if (t == inj_t + 1) begin
        req_valid = 1'b0; req_m = 12'(m);
      end
      if (!p_byp && byp) t_byp_rise = t;
      if (p_byp && !byp) t_unbyp = t;
      if (p_en && !en) t_en_fall = t;
      if (!p_en && en) t_en_rise = t;
      if (!p_pwr && pwr) t_pwr_rise = t;
      if (p_pwr && !pwr) t_pwr_fall = t;
      if (!p_rst && rst) begin
        t_rst_rise = t;
        f_mult = int'(mult); f_prediv = int'(prediv); f_postdiv = int'(postdiv);
        f_lo = int'(bw_lo); f_hi = int'(bw_hi);
      end
      if (p_rst && !rst) t_rst_fall = t;
      if (done) begin done_cnt++; t_done = t; end
      if (!p_rdy && ready) t_ready = t;
      p_byp = byp; p_en = en; p_pwr = pwr; p_rst = rst; p_rdy = ready;
    end
  endtask

  task automatic test_reset_state;
    chk("R12 ready", int'(ready), 1);
    chk("R12 bypass", int'(byp), 1);
    chk("R12 en", int'(en), 0);
    chk("R12 pwrdn", int'(pwr), 0);
    chk("R12 rst", int'(rst), 0);
    chk("R12 sat", int'(sat), 0);
    chk("R12 done", int'(done), 0);
  endtask

  task automatic test_from_bypass;
    run_seq(20, 2, 2, 1, -1);
    chk("R5 pwrdn rise after settle+quiet", t_pwr_rise, 1003);
    chk("R6 pwrdn length", t_pwr_fall, 1053);
    chk("R6 sat set", int'(sat), 1);
    chk("R7 rst rise", t_rst_rise, 1054);
    chk("R7 rst fall", t_rst_fall, 1124);
    chk("R8 lock fixed", t_unbyp - t_rst_fall, 500);
    chk("R9 enable after unbypass", t_en_rise, t_unbyp + 1);
    chk("R9 done cycle", t_done, t_en_rise);
    chk("R9 done count", done_cnt, 1);
    chk("R2 mult", f_mult, 19);
    chk("R2 prediv", f_prediv, 1);
    chk("R2 postdiv", f_postdiv, 1);
    chk("R3 bw_lo", f_lo, 9);
    chk("R3 bw_hi", f_hi, 0);
    chk("R10 ready return", t_ready, 2625);
    chk("R11 total from bypass", t_done, 1625);
  endtask

  task automatic test_running_pll;
    run_seq(1000, 1, 1, 0, -1);
    chk("R4 en fall at settle", t_en_fall, 999);
    chk("R4 bypass rise at settle", t_byp_rise, 999);
    chk("R6 no pwrdn", t_pwr_rise, -1);
    chk("R5 rst rise after quiet", t_rst_rise, 1004);
    chk("R2 mult", f_mult, 999);
    chk("R2 prediv", f_prediv, 0);
    chk("R2 postdiv", f_postdiv, 0);
    chk("R3 bw_lo", f_lo, 243);
    chk("R3 bw_hi", f_hi, 1);
    chk("R9 done", t_done, 1575);
    chk("R10 ready", t_ready, 2575);
  endtask

  task automatic test_busy_ignored;
    run_seq(4095, 63, 15, 0, 1300);
    chk("R1 ready low while busy", ready_at_inj, 0);
    chk("R1 single done", done_cnt, 1);
    chk("R2 mult max", f_mult, 4094);
    chk("R2 prediv max", f_prediv, 62);
    chk("R2 postdiv max", f_postdiv, 14);
    chk("R3 bw_lo max", f_lo, 255);
    chk("R3 bw_hi max", f_hi, 7);
    repeat (20) @(negedge clk);
    chk("R1 still idle", int'(ready), 1);
    chk("R1 still enabled", int'(en), 1);
    chk("R1 mult kept", int'(mult), 4094);
  endtask

  task automatic test_div_lock;
    int t, tf, tu, td;
    logic pr, pb;
    tf = -1; tu = -1; td = -1;
    @(negedge clk);
    req_m = 12'd8; req_d = 6'd4; req_od = 4'd2; in_bypass = 1'b0;
    req_valid2 = 1'b1;
    @(negedge clk);
    req_valid2 = 1'b0;
    t = 0; pr = rst2; pb = byp2;
    while (t < 5000 && td < 0) begin
      @(negedge clk);
      t++;
      if (pr && !rst2) tf = t;
      if (pb && !byp2) tu = t;
      if (done2) td = t;
      pr = rst2; pb = byp2;
    end
    chk("R8 lock from divider", tu - tf, 2000);
    chk("R9 done after unbypass", td - tu, 1);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    test_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    test_from_bypass();
    test_running_pll();
    test_busy_ignored();
    test_div_lock();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule